// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a byte address for a flat, byte-addressable 32-bit memory space from operand fields that a decoder has already pulled out of an instruction. A three-bit mode code chooses which terms enter the sum: an optional base register value, an optional index register value shifted left by a two-bit scale code, and an optional displacement. The displacement arrives as a raw 32-bit field with a size tag. When the tag marks it short, only its low byte is used, sign-extended.

The result and a valid flag are registered, so an address presented with `in_valid` high appears at the outputs one clock later. The adders wrap modulo 2^32 and no alignment rule is applied, because operands may start at any byte. Register-file reads, decoding, segmentation and the memory access itself are done elsewhere.

Top module: `eag_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next output state is `ea_valid` = 0 and `ea_out` = 0.
- R2: `ea_valid` equals, one clock later, `in_valid` AND (`mode` is 0 to 5). The address for a vector appears on `ea_out` in that same cycle.
- R3: Every sum wraps modulo 2^32, with no overflow indication.
- R4: Mode 0 (absolute) outputs all 32 bits of `disp_raw` unchanged, whatever the value of `disp_long`.
- R5: Mode 1 (register) outputs `base_val` unchanged. The index, scale and displacement inputs have no effect.
- R6: Mode 2 outputs `base_val` + displacement.
- R7: Mode 3 outputs displacement + (`index_val` × scale factor). `base_val` has no effect.
- R8: Mode 4 outputs `base_val` + (`index_val` × scale factor). The displacement has no effect.
- R9: Mode 5 outputs `base_val` + (`index_val` × scale factor) + displacement.
- R10: `scale_code` values 0, 1, 2 and 3 select factors of 1, 2, 4 and 8.
- R11: In modes 2, 3 and 5, `disp_long` = 1 uses all 32 bits of `disp_raw`. `disp_long` = 0 uses `disp_raw[7:0]` sign-extended to 32 bits, and bits 31:8 are then ignored.
- R12: When `in_valid` is low, or `mode` is 6 or 7, `ea_valid` goes low in the next cycle and `ea_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand fields are valid this cycle |
| mode | input | 3 | Addressing mode code (0 to 5 legal) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp_raw | input | 32 | Raw displacement field |
| disp_long | input | 1 | 1: 32-bit displacement, 0: 8-bit signed displacement |
| ea_out | output | 32 | Registered effective address |
| ea_valid | output | 1 | Registered valid flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit short displacement and a 2-bit scale code. With these values, directed operands placed near 2^32 reach the wraparound cases. All four shift amounts and both displacement sizes are exercised. The two reserved mode codes can also be driven from the port, so the hold behaviour on an illegal or idle cycle is checked against the reference model as well.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        AM_ABS          = 3'd0,
        AM_REG          = 3'd1,
        AM_BASE_OFS     = 3'd2,
        AM_IDX_OFS      = 3'd3,
        AM_BASE_IDX     = 3'd4,
        AM_BASE_IDX_OFS = 3'd5,
        AM_RSV6         = 3'd6,
        AM_RSV7         = 3'd7
    } amode_e;

    // which terms enter the sum for a given mode
    typedef struct packed {
        logic legal;
        logic take_base;
        logic take_index;
        logic take_disp;
        logic disp_whole;   // displacement used at full width regardless of tag
    } term_sel_t;

    function automatic term_sel_t decode_mode(input amode_e m);
        term_sel_t t;
        t = '0;
        unique case (m)
            AM_ABS: begin
                t.legal      = 1'b1;
                t.take_disp  = 1'b1;
                t.disp_whole = 1'b1;
            end
            AM_REG: begin
                t.legal     = 1'b1;
                t.take_base = 1'b1;
            end
            AM_BASE_OFS: begin
                t.legal     = 1'b1;
                t.take_base = 1'b1;
                t.take_disp = 1'b1;
            end
            AM_IDX_OFS: begin
                t.legal      = 1'b1;
                t.take_index = 1'b1;
                t.take_disp  = 1'b1;
            end
            AM_BASE_IDX: begin
                t.legal      = 1'b1;
                t.take_base  = 1'b1;
                t.take_index = 1'b1;
            end
            AM_BASE_IDX_OFS: begin
                t.legal      = 1'b1;
                t.take_base  = 1'b1;
                t.take_index = 1'b1;
                t.take_disp  = 1'b1;
            end
            default: t = '0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 8
) (
    input  logic [ADDR_W-1:0] raw,
    input  logic              long_tag,
    input  logic              whole,
    output logic [ADDR_W-1:0] ext
);
    localparam int PAD_W = ADDR_W - SHORT_W;

    logic [SHORT_W-1:0] short_part;
    logic [ADDR_W-1:0]  short_ext;

    assign short_part = raw[SHORT_W-1:0];
    assign short_ext  = {{PAD_W{short_part[SHORT_W-1]}}, short_part};

    always_comb begin
        if (whole || long_tag) begin
            ext = raw;
        end else begin
            ext = short_ext;
        end
    end
endmodule

// File: rtl/eag_index_scale.sv
module eag_index_scale #(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  idx,
    input  logic [SCALE_W-1:0] sc,
    output logic [ADDR_W-1:0]  scaled
);
    localparam int N_SHIFT = 1 << SCALE_W;

    logic [ADDR_W-1:0] cand [N_SHIFT];

    for (genvar s = 0; s < N_SHIFT; s++) begin : g_shift
        assign cand[s] = idx << s;
    end

    assign scaled = cand[sc];
endmodule

// File: rtl/eag_term_adder.sv
module eag_term_adder
    import eag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  term_sel_t         sel,
    input  logic [ADDR_W-1:0] base_v,
    input  logic [ADDR_W-1:0] idx_scaled,
    input  logic [ADDR_W-1:0] disp_ext,
    output logic [ADDR_W-1:0] sum
);
    logic [ADDR_W-1:0] t_base;
    logic [ADDR_W-1:0] t_idx;
    logic [ADDR_W-1:0] t_disp;

    assign t_base = sel.take_base  ? base_v     : '0;
    assign t_idx  = sel.take_index ? idx_scaled : '0;
    assign t_disp = sel.take_disp  ? disp_ext   : '0;

    // three-term add; carry out beyond ADDR_W bits is dropped
    assign sum = t_base + t_idx + t_disp;
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 8,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         mode,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [ADDR_W-1:0]  disp_raw,
    input  logic               disp_long,
    output logic [ADDR_W-1:0]  ea_out,
    output logic               ea_valid
);
    term_sel_t         sel;
    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] idx_x;
    logic [ADDR_W-1:0] ea_next;
    logic              take;

    assign sel  = decode_mode(amode_e'(mode));
    assign take = in_valid && sel.legal;

    eag_disp_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_disp (
        .raw      (disp_raw),
        .long_tag (disp_long),
        .whole    (sel.disp_whole),
        .ext      (disp_x)
    );

    eag_index_scale #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
        .idx    (index_val),
        .sc     (scale_code),
        .scaled (idx_x)
    );

    eag_term_adder #(.ADDR_W(ADDR_W)) u_add (
        .sel        (sel),
        .base_v     (base_val),
        .idx_scaled (idx_x),
        .disp_ext   (disp_x),
        .sum        (ea_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_out   <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea_valid <= take;
            if (take) begin
                ea_out <= ea_next;
            end
        end
    end
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [2:0]         mode,
    input logic [ADDR_W-1:0]  base_val,
    input logic [ADDR_W-1:0]  index_val,
    input logic [SCALE_W-1:0] scale_code,
    input logic [ADDR_W-1:0]  disp_raw,
    input logic [ADDR_W-1:0]  ea_out,
    input logic               ea_valid
);
    logic go;
    assign go = in_valid && (mode < 3'd6);

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        go |=> ea_valid);

    a_r12_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !go |=> !ea_valid);

    a_r12_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(ea_out));

    a_r4_absolute: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd0) |=> ea_out == $past(disp_raw));

    a_r5_register: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd1) |=> ea_out == $past(base_val));

    a_r8_base_index: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd4) |=>
            ea_out == $past(base_val + (index_val << scale_code)));
endmodule

bind eag_top eag_checker #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode       (mode),
    .base_val   (base_val),
    .index_val  (index_val),
    .scale_code (scale_code),
    .disp_raw   (disp_raw),
    .ea_out     (ea_out),
    .ea_valid   (ea_valid)
);

// File: tb/eag_top_bench.sv
module eag_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  mode;
    logic [31:0] base_val, index_val, disp_raw;
    logic [1:0]  scale_code;
    logic        disp_long;
    logic [31:0] ea_out;
    logic        ea_valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] ref_addr = 32'h0;
    logic        ref_valid = 1'b0;

    always #5 clk = ~clk;

    eag_top u_eag_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .base_val(base_val), .index_val(index_val), .scale_code(scale_code),
        .disp_raw(disp_raw), .disp_long(disp_long),
        .ea_out(ea_out), .ea_valid(ea_valid)
    );

    function automatic logic [31:0] ref_ea(input logic [2:0] m, input logic [31:0] b,
                                           input logic [31:0] x, input logic [1:0] s,
                                           input logic [31:0] d, input logic lg);
        longint dv, acc, xs;
        dv  = lg ? longint'(d) : longint'($signed(d[7:0]));
        xs  = longint'(x) * (longint'(1) << s);
        acc = 0;
        case (m)
            3'd0: acc = longint'(d);
            3'd1: acc = longint'(b);
            3'd2: acc = longint'(b) + dv;
            3'd3: acc = dv + xs;
            3'd4: acc = longint'(b) + xs;
            3'd5: acc = longint'(b) + xs + dv;
            default: acc = 0;
        endcase
        return acc[31:0];
    endfunction

    task automatic compare(input string req);
        vectors++;
        if (ea_valid !== ref_valid || ea_out !== ref_addr) begin
            miscompares++;
            $display("FAIL %s: got valid=%0b addr=%08h, expected valid=%0b addr=%08h",
                     req, ea_valid, ea_out, ref_valid, ref_addr);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] m, input logic [31:0] b,
                         input logic [31:0] x, input logic [1:0] s,
                         input logic [31:0] d, input logic lg, input string req);
        @(negedge clk);
        in_valid = v; mode = m; base_val = b; index_val = x;
        scale_code = s; disp_raw = d; disp_long = lg;
        @(posedge clk);
        ref_valid = v && (m < 3'd6);
        if (ref_valid) ref_addr = ref_ea(m, b, x, s, d, lg);
        #1;
        compare(req);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b1; mode = 3'd2; base_val = 32'hDEAD_BEEF;
        index_val = 32'h1; scale_code = 2'd3; disp_raw = 32'h55; disp_long = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        ref_valid = 1'b0; ref_addr = 32'h0;
        compare("R1 reset");
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        // R4: absolute ignores size tag
        apply(1, 3'd0, 32'h1111_1111, 32'h2, 2'd1, 32'h1234_5680, 1'b0, "R4 absolute short tag");
        apply(1, 3'd0, 32'h0, 32'h0, 2'd0, 32'hFFFF_0001, 1'b1, "R4 absolute long tag");
        // R5: register indirect
        apply(1, 3'd1, 32'h0040_1000, 32'h7777_7777, 2'd3, 32'h9999_9999, 1'b1, "R5 register");
        // R6 / R11
        apply(1, 3'd2, 32'h0000_1000, 32'h0, 2'd0, 32'h0000_00F0, 1'b0, "R6 R11 negative short disp");
        apply(1, 3'd2, 32'h0000_1000, 32'h5, 2'd2, 32'hABCD_00F0, 1'b0, "R11 short disp upper bits ignored");
        apply(1, 3'd2, 32'h0000_1000, 32'h0, 2'd0, 32'h0000_0200, 1'b1, "R6 long disp");
        apply(1, 3'd2, 32'h0000_1000, 32'h0, 2'd0, 32'h0000_007F, 1'b0, "R11 positive short disp");
        // R7: base ignored
        apply(1, 3'd3, 32'hFFFF_0000, 32'h0000_0010, 2'd3, 32'h0000_0100, 1'b1, "R7 index plus disp");
        // R8 / R10: all scales
        for (int s = 0; s < 4; s++)
            apply(1, 3'd4, 32'h0000_2000, 32'h0000_0003, s[1:0], 32'h0000_FFFF, 1'b1, "R8 R10 scale sweep");
        // R9
        apply(1, 3'd5, 32'h0010_0000, 32'h0000_0040, 2'd2, 32'h0000_0080, 1'b0, "R9 full short disp");
        apply(1, 3'd5, 32'h0010_0000, 32'h0000_0040, 2'd1, 32'h8000_0000, 1'b1, "R9 full long disp");
        // R3 wraparound
        apply(1, 3'd2, 32'hFFFF_FFF0, 32'h0, 2'd0, 32'h0000_0020, 1'b0, "R3 wrap base plus disp");
        apply(1, 3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 32'hFFFF_FFFF, 1'b1, "R3 wrap full");
        apply(1, 3'd3, 32'h0, 32'h4000_0000, 2'd2, 32'h0000_0001, 1'b1, "R3 wrap scaled index");
        // R12 holds
        apply(0, 3'd2, 32'h1234_0000, 32'h1, 2'd1, 32'h10, 1'b1, "R12 idle holds address");
        apply(1, 3'd6, 32'h5555_0000, 32'h1, 2'd1, 32'h10, 1'b1, "R12 mode 6 rejected");
        apply(1, 3'd7, 32'h6666_0000, 32'h2, 2'd2, 32'h20, 1'b0, "R12 mode 7 rejected");
        // R2 back-to-back latency
        apply(1, 3'd1, 32'hCAFE_0000, 32'h0, 2'd0, 32'h0, 1'b0, "R2 back-to-back first");
        apply(1, 3'd1, 32'hCAFE_0004, 32'h0, 2'd0, 32'h0, 1'b0, "R2 back-to-back second");

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic [2:0] rm;
            rm = 3'($urandom_range(0, 7));
            apply(1'($urandom_range(0, 9) != 0), rm, $urandom, $urandom,
                  2'($urandom_range(0, 3)), $urandom, 1'($urandom_range(0, 1)),
                  "R2 R9 random mix");
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule